// File: doc/BRIEF.md
# Serial EEPROM Page Write Sequencer

This block is the write side of a small serial EEPROM. It sits behind a two-wire bus slave front end, which turns bus activity into simple decoded events. The front end reports a start condition, a stop condition, a received byte tagged with its place in the frame (command, word address or data), and an acknowledge strobe. The block takes the word address into an address counter. It then collects data bytes into an eight-entry page buffer. A per-entry mask records which entries were loaded.

A stop condition ends the transfer. If at least one data byte was loaded, the stop launches a self-timed programming cycle. In the first half of the cycle, every loaded location of the page is erased to all ones. In the second half, those locations take the buffered values. Locations in the page that were not loaded keep their old contents. While the cycle runs, `busy` is high, so the front end withholds its acknowledge and the bus master can poll for completion. A plain combinational read port exposes the cell array to the read side of the device.

The cycle length `PROG_CYCLES` is set in clock cycles. It must be chosen no longer than 8 ms at the system clock.

Top module: `eep_page_writer`

## Requirements
- R1: After reset, `busy` is 0, `cur_addr` is 0 and every array location reads 0xFF.
- R2: A received byte with `rx_pos` = 1 (word address) loads `cur_addr` with its low `AW` bits on the next clock.
- R3: A received byte with `rx_pos` = 2 (data) is stored in the buffer entry selected by the three low bits of `cur_addr`. `cur_addr` does not move until the next `ack_stb`, which then advances it by one. An `ack_stb` after a command byte or a word address byte leaves `cur_addr` unchanged.
- R4: Only the three low bits of `cur_addr` count, wrapping from 7 to 0. The upper page bits never change through counting.
- R5: A stop condition, with at least one data byte loaded since the last start or word address, raises `busy` on the next clock. `busy` then stays high for exactly `PROG_CYCLES` cycles.
- R6: During the first half of the cycle, every loaded location reads 0xFF.
- R7: After the cycle, each loaded location holds its buffered byte, and every other location is unchanged.
- R8: When more than eight data bytes arrive, a later byte replaces the earlier byte in the same buffer entry.
- R9: A stop with no data byte loaded since the last start or word address does not start a cycle. A start discards any loaded bytes.
- R10: While `busy` is high, received bytes, acknowledges, starts and stops are ignored. `cur_addr` and the array are left as they were.
- R11: With `DEPTH` = 128, the most significant bit of the word address byte is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ev_start | input | 1 | Start condition seen (one-cycle pulse) |
| ev_stop | input | 1 | Stop condition seen (one-cycle pulse) |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_pos | input | 2 | Frame position of the byte: 0 command, 1 word address, 2 data |
| rx_byte | input | 8 | Received byte |
| ack_stb | input | 1 | The current byte has been acknowledged |
| busy | output | 1 | Programming cycle in progress; the front end must not acknowledge |
| cur_addr | output | AW | Current word address counter |
| rd_addr | input | AW | Array read address |
| rd_data | output | 8 | Array contents at `rd_addr` |

## Verification
The page write is tried with four patterns:
- a short run of two bytes inside one page;
- a single byte written over earlier data;
- a run that starts near the page end and wraps;
- a run of nine bytes that overflows the buffer.

The overwrite case is the one that separates erase from write: the target must read 0xFF in mid-cycle and its neighbour must keep its old value. The wrap and overflow runs tell a three-bit counter apart from a full-width one, and show whether later bytes replace earlier ones. Stops with nothing loaded, traffic sent during `busy`, and a second instance with 128 bytes cover the cases where nothing should happen.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int PAGE_BYTES = 8;
    localparam int PAGE_BITS  = 3;

    localparam logic [1:0] POS_CMD  = 2'd0;
    localparam logic [1:0] POS_ADDR = 2'd1;
    localparam logic [1:0] POS_DATA = 2'd2;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_ERASE = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/eep_page_buf.sv
module eep_page_buf
    import eep_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      ld,
    input  logic [PAGE_BITS-1:0]      ld_idx,
    input  logic [7:0]                ld_data,
    output logic [PAGE_BYTES*8-1:0]   page_data,
    output logic [PAGE_BYTES-1:0]     page_mask
);
    typedef struct packed {
        logic [PAGE_BYTES-1:0][7:0] data;
        logic [PAGE_BYTES-1:0]      mask;
    } buf_t;

    buf_t buf_d, buf_q;

    always_comb begin
        buf_d = buf_q;
        if (clr) begin
            buf_d.mask = '0;
        end else if (ld) begin
            buf_d.data[ld_idx] = ld_data;
            buf_d.mask[ld_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) buf_q <= '0;
        else        buf_q <= buf_d;
    end

    assign page_data = buf_q.data;
    assign page_mask = buf_q.mask;
endmodule

// File: rtl/eep_prog_seq.sv
module eep_prog_seq
    import eep_pkg::*;
#(
    parameter int PROG_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy,
    output logic erase_stb,
    output logic write_stb,
    output logic done_stb
);
    localparam int HALF = (PROG_CYCLES / 2 < 1) ? 1 : PROG_CYCLES / 2;
    localparam int REST = (PROG_CYCLES - HALF < 1) ? 1 : PROG_CYCLES - HALF;
    localparam int CW   = $clog2(PROG_CYCLES + 1);

    typedef struct packed {
        seq_state_e     st;
        logic [CW-1:0]  cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d     = seq_q;
        erase_stb = 1'b0;
        write_stb = 1'b0;
        done_stb  = 1'b0;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (go) begin
                    seq_d.st  = SEQ_ERASE;
                    seq_d.cnt = '0;
                end
            end
            SEQ_ERASE: begin
                erase_stb = (seq_q.cnt == '0);
                if (seq_q.cnt == CW'(HALF - 1)) begin
                    seq_d.st  = SEQ_WRITE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + {{(CW-1){1'b0}}, 1'b1};
                end
            end
            SEQ_WRITE: begin
                write_stb = (seq_q.cnt == '0);
                if (seq_q.cnt == CW'(REST - 1)) begin
                    done_stb  = 1'b1;
                    seq_d.st  = SEQ_IDLE;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + {{(CW-1){1'b0}}, 1'b1};
                end
            end
            default: seq_d.st = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{st: SEQ_IDLE, cnt: '0};
        else        seq_q <= seq_d;
    end

    assign busy = (seq_q.st != SEQ_IDLE);
endmodule

// File: rtl/eep_cell_array.sv
module eep_cell_array
    import eep_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        erase_stb,
    input  logic                        write_stb,
    input  logic [$clog2(DEPTH)-PAGE_BITS-1:0] page_idx,
    input  logic [PAGE_BYTES-1:0]       lane_mask,
    input  logic [PAGE_BYTES*8-1:0]     lane_data,
    input  logic [$clog2(DEPTH)-1:0]    rd_addr,
    output logic [7:0]                  rd_data
);
    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int a = 0; a < DEPTH; a++) mem[a] <= 8'hFF;
        end else if (erase_stb || write_stb) begin
            for (int i = 0; i < PAGE_BYTES; i++) begin
                if (lane_mask[i]) begin
                    mem[{page_idx, i[PAGE_BITS-1:0]}] <=
                        erase_stb ? 8'hFF : lane_data[i*8 +: 8];
                end
            end
        end
    end

    assign rd_data = mem[rd_addr];
endmodule

// File: rtl/eep_page_writer.sv
module eep_page_writer
    import eep_pkg::*;
#(
    parameter int DEPTH       = 256,
    parameter int PROG_CYCLES = 400,
    localparam int AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ev_start,
    input  logic          ev_stop,
    input  logic          rx_valid,
    input  logic [1:0]    rx_pos,
    input  logic [7:0]    rx_byte,
    input  logic          ack_stb,
    output logic          busy,
    output logic [AW-1:0] cur_addr,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic          pend;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic                    buf_clr, buf_ld, seq_go;
    logic                    erase_stb, write_stb, done_stb;
    logic [PAGE_BYTES*8-1:0] page_data;
    logic [PAGE_BYTES-1:0]   page_mask;
    logic [PAGE_BITS-1:0]    low_next;

    assign low_next = ctl_q.addr[PAGE_BITS-1:0] + {{(PAGE_BITS-1){1'b0}}, 1'b1};

    always_comb begin
        ctl_d   = ctl_q;
        buf_clr = done_stb;
        buf_ld  = 1'b0;
        seq_go  = 1'b0;
        if (!busy) begin
            if (ev_start) begin
                ctl_d.pend = 1'b0;
                buf_clr    = 1'b1;
            end else if (ev_stop) begin
                ctl_d.pend = 1'b0;
                seq_go     = |page_mask;
            end else if (rx_valid) begin
                ctl_d.pend = 1'b0;
                if (rx_pos == POS_ADDR) begin
                    ctl_d.addr = rx_byte[AW-1:0];
                    buf_clr    = 1'b1;
                end else if (rx_pos == POS_DATA) begin
                    buf_ld     = 1'b1;
                    ctl_d.pend = 1'b1;
                end
            end else if (ack_stb && ctl_q.pend) begin
                ctl_d.addr = {ctl_q.addr[AW-1:PAGE_BITS], low_next};
                ctl_d.pend = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cur_addr = ctl_q.addr;

    eep_page_buf u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (buf_clr),
        .ld        (buf_ld),
        .ld_idx    (ctl_q.addr[PAGE_BITS-1:0]),
        .ld_data   (rx_byte),
        .page_data (page_data),
        .page_mask (page_mask)
    );

    eep_prog_seq #(.PROG_CYCLES(PROG_CYCLES)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (seq_go),
        .busy      (busy),
        .erase_stb (erase_stb),
        .write_stb (write_stb),
        .done_stb  (done_stb)
    );

    eep_cell_array #(.DEPTH(DEPTH)) u_arr (
        .clk       (clk),
        .rst_n     (rst_n),
        .erase_stb (erase_stb),
        .write_stb (write_stb),
        .page_idx  (ctl_q.addr[AW-1:PAGE_BITS]),
        .lane_mask (page_mask),
        .lane_data (page_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/eep_page_writer_chk.sv
module eep_page_writer_chk #(
    parameter int AW          = 8,
    parameter int PROG_CYCLES = 400
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ev_stop,
    input logic          rx_valid,
    input logic          ack_stb,
    input logic          busy,
    input logic [AW-1:0] cur_addr
);
    localparam int PB = eep_pkg::PAGE_BITS;

    logic        started_q;
    logic [31:0] bcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            started_q <= 1'b0;
            bcnt_q    <= '0;
        end else begin
            started_q <= 1'b1;
            bcnt_q    <= busy ? bcnt_q + 32'd1 : 32'd0;
        end
    end

    // R5
    cycle_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $rose(busy)) |-> $past(ev_stop));

    // R5
    cycle_length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && $fell(busy)) |-> (bcnt_q == 32'(PROG_CYCLES)));

    // R10
    busy_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && busy) |=> $stable(cur_addr));

    // R4
    page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !busy && ack_stb && !rx_valid)
        |=> (cur_addr[AW-1:PB] == $past(cur_addr[AW-1:PB])));

    // R3
    addr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (started_q && !rx_valid && !ack_stb) |=> $stable(cur_addr));
endmodule

bind eep_page_writer eep_page_writer_chk #(.AW(AW), .PROG_CYCLES(PROG_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev_stop  (ev_stop),
    .rx_valid (rx_valid),
    .ack_stb  (ack_stb),
    .busy     (busy),
    .cur_addr (cur_addr)
);

// File: tb/test_eep_page_writer.sv
module test_eep_page_writer;
    localparam int PROG = 64;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_start = 1'b0, ev_stop = 1'b0, rx_valid = 1'b0, ack_stb = 1'b0;
    logic [1:0] rx_pos = 2'd0;
    logic [7:0] rx_byte = 8'h00;
    logic [7:0] rd_addr = 8'h00;
    logic       busy, s_busy;
    logic [7:0] cur_addr, rd_data, s_rd_data;
    logic [6:0] s_cur_addr;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    eep_page_writer #(.DEPTH(256), .PROG_CYCLES(PROG)) i_eep_page_writer (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .rx_valid(rx_valid), .rx_pos(rx_pos), .rx_byte(rx_byte), .ack_stb(ack_stb),
        .busy(busy), .cur_addr(cur_addr), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    eep_page_writer #(.DEPTH(128), .PROG_CYCLES(PROG)) i_eep_page_writer_small (
        .clk(clk), .rst_n(rst_n), .ev_start(ev_start), .ev_stop(ev_stop),
        .rx_valid(rx_valid), .rx_pos(rx_pos), .rx_byte(rx_byte), .ack_stb(ack_stb),
        .busy(s_busy), .cur_addr(s_cur_addr), .rd_addr(rd_addr[6:0]), .rd_data(s_rd_data)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic peek(input logic [7:0] a, output logic [7:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    task automatic chk_mem(string req, logic [7:0] a, logic [7:0] exp);
        logic [7:0] v;
        peek(a, v);
        chk(req, v, exp);
    endtask

    task automatic send(logic [1:0] pos, logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_pos = pos; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic ack();
        @(negedge clk); ack_stb = 1'b1;
        @(negedge clk); ack_stb = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); ev_start = 1'b1;
        @(negedge clk); ev_start = 1'b0;
    endtask

    task automatic begin_frame(logic [7:0] a);
        pulse_start();
        send(2'd0, 8'hA0);
        ack();
        send(2'd1, a);
        ack();
    endtask

    task automatic data_ack(logic [7:0] b);
        send(2'd2, b);
        ack();
    endtask

    // Stop, then count busy cycles; optional mid-erase checks
    task automatic stop_cycle(bit do_erase, logic [7:0] ea, logic [7:0] ka, logic [7:0] kv);
        int n;
        @(negedge clk); ev_stop = 1'b1;
        @(negedge clk); ev_stop = 1'b0;
        n = 0;
        while (busy && n < PROG + 10) begin
            n++;
            if (n == 2 && do_erase) begin
                chk_mem("R6 erased in first half", ea, 8'hFF);
                chk_mem("R7 neighbour kept during erase", ka, kv);
            end
            @(negedge clk);
        end
        chk("R5 busy length", n, PROG);
    endtask

    task automatic quiet_stop(string req);
        int hi;
        @(negedge clk); ev_stop = 1'b1;
        @(negedge clk); ev_stop = 1'b0;
        hi = 0;
        for (int k = 0; k < 5; k++) begin
            if (busy) hi++;
            @(negedge clk);
        end
        chk(req, hi, 0);
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", busy, 0);
        chk("R1 cur_addr after reset", cur_addr, 0);
        chk_mem("R1 array erased", 8'h00, 8'hFF);
        chk_mem("R1 array erased", 8'hFF, 8'hFF);
    endtask

    task automatic t_short_run();
        begin_frame(8'h13);
        chk("R2 address captured", cur_addr, 8'h13);
        send(2'd2, 8'hA1);
        chk("R3 no advance before ack", cur_addr, 8'h13);
        ack();
        chk("R3 advance after ack", cur_addr, 8'h14);
        data_ack(8'hA2);
        chk("R3 second advance", cur_addr, 8'h15);
        stop_cycle(1'b0, 8'h00, 8'h00, 8'h00);
        chk_mem("R7 first byte", 8'h13, 8'hA1);
        chk_mem("R7 second byte", 8'h14, 8'hA2);
        chk_mem("R7 unloaded below", 8'h12, 8'hFF);
        chk_mem("R7 unloaded above", 8'h15, 8'hFF);
    endtask

    task automatic t_overwrite();
        begin_frame(8'h13);
        data_ack(8'h5C);
        stop_cycle(1'b1, 8'h13, 8'h14, 8'hA2);
        chk_mem("R7 rewritten byte", 8'h13, 8'h5C);
        chk_mem("R7 untouched neighbour", 8'h14, 8'hA2);
    endtask

    task automatic t_wrap();
        begin_frame(8'h2E);
        data_ack(8'hB0);
        data_ack(8'hB1);
        chk("R4 low bits wrap, page kept", cur_addr, 8'h28);
        data_ack(8'hB2);
        data_ack(8'hB3);
        chk("R4 after wrap", cur_addr, 8'h2A);
        stop_cycle(1'b0, 8'h00, 8'h00, 8'h00);
        chk_mem("R4 slot 6", 8'h2E, 8'hB0);
        chk_mem("R4 slot 7", 8'h2F, 8'hB1);
        chk_mem("R4 slot 0", 8'h28, 8'hB2);
        chk_mem("R4 slot 1", 8'h29, 8'hB3);
        chk_mem("R7 slot 2 untouched", 8'h2A, 8'hFF);
        chk_mem("R4 next page untouched", 8'h30, 8'hFF);
    endtask

    task automatic t_overflow();
        begin_frame(8'h40);
        for (int i = 0; i < 9; i++) data_ack(8'hC0 + 8'(i));
        chk("R8 counter wrapped to slot 1", cur_addr, 8'h41);
        stop_cycle(1'b0, 8'h00, 8'h00, 8'h00);
        chk_mem("R8 slot 0 replaced", 8'h40, 8'hC8);
        chk_mem("R8 slot 1 kept", 8'h41, 8'hC1);
        chk_mem("R8 slot 7", 8'h47, 8'hC7);
    endtask

    task automatic t_no_data();
        begin_frame(8'h60);
        quiet_stop("R9 stop after address only");
        pulse_start();
        quiet_stop("R9 stop after bare start");
        begin_frame(8'h60);
        data_ack(8'h77);
        pulse_start();
        quiet_stop("R9 start discards loaded bytes");
        chk_mem("R9 array untouched", 8'h60, 8'hFF);
    endtask

    task automatic t_busy_ignore();
        int n;
        begin_frame(8'h70);
        data_ack(8'h11);
        @(negedge clk); ev_stop = 1'b1;
        @(negedge clk); ev_stop = 1'b0;
        n = 1;
        send(2'd1, 8'h05); n += 2;
        send(2'd2, 8'h99); n += 2;
        ack(); n += 2;
        chk("R10 cur_addr held while busy", cur_addr, 8'h71);
        @(negedge clk); ev_stop = 1'b1; ev_start = 1'b1;
        @(negedge clk); ev_stop = 1'b0; ev_start = 1'b0; n += 2;
        while (busy && n < PROG + 20) begin
            n++;
            @(negedge clk);
        end
        chk("R5 busy length with traffic", n - 1, PROG);
        chk_mem("R10 page written", 8'h70, 8'h11);
        chk_mem("R10 ignored data not written", 8'h05, 8'hFF);
        chk_mem("R10 ignored data not in page", 8'h71, 8'hFF);
        n = 0;
        for (int k = 0; k < 5; k++) begin
            if (busy) n++;
            @(negedge clk);
        end
        chk("R10 stop during busy not replayed", n, 0);
    endtask

    task automatic t_small();
        logic [7:0] v;
        chk("R11 small array untouched", s_cur_addr, s_cur_addr);
        rd_addr = 8'h05; #1;
        chk("R11 small location before", s_rd_data, 8'hFF);
        begin_frame(8'h85);
        chk("R11 msb dropped", s_cur_addr, 7'h05);
        chk("R2 full width kept", cur_addr, 8'h85);
        data_ack(8'h3C);
        stop_cycle(1'b0, 8'h00, 8'h00, 8'h00);
        peek(8'h05, v);
        chk("R11 small written at low address", s_rd_data, 8'h3C);
        chk_mem("R11 wide written at full address", 8'h85, 8'h3C);
    endtask

    bit finished = 1'b0;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short_run();
        t_overwrite();
        t_wrap();
        t_overflow();
        t_no_data();
        t_busy_ignore();
        t_small();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule